// File: doc/BRIEF.md
# Tagged Add/Subtract with Trap

This unit performs 32-bit addition or subtraction on tagged integers, where the two least significant bits of each operand carry a type tag that must be zero for a legal operation. A single strobe presents two operands and an add/subtract select. One clock later the unit reports either a trap or a valid result. The trap is raised when an operand has a nonzero tag, or when the signed arithmetic overflows.

Alongside the result, the unit keeps a registered flag-state bundle for a downstream condition-code stage. The bundle holds an operation code, both source operands and the result. It is committed only when an operation finishes without a trap. A trapping operation, or a cycle without a strobe, leaves the previous bundle in place. This is what allows the trap handler to see the flag state exactly as it was before the faulting instruction.

Top module: `tagged_arith_trap`

## Requirements
- R1: If bit 0 or bit 1 of either operand is set on a strobed operation, `trap` is 1 in the following cycle, for both add and subtract.
- R2: For addition with clean tags, `trap` is raised when both operands have the same bit 31 and bit 31 of the 32-bit sum differs from bit 31 of `src_a`.
- R3: For subtraction with clean tags, `trap` is raised when the operands differ in bit 31 and bit 31 of the 32-bit difference differs from bit 31 of `src_a`.
- R4: `trap` and `res_valid` are registered outputs that reflect the operation strobed in the previous cycle. They are never 1 together, and both are 0 in the cycle after a cycle without a strobe.
- R5: `result` shows `src_a + src_b` (`op_sub`=0) or `src_a - src_b` (`op_sub`=1), modulo 2^32, in the cycle after every strobe, including trapping ones. It holds its value in the cycle after a cycle without a strobe.
- R6: After a strobed operation that does not trap, the flag bundle holds that operation's `src_a`, `src_b` and result, with `flag_res` equal to `result`.
- R7: After a trapping operation, or after a cycle without a strobe, all four flag-bundle outputs keep their previous values.
- R8: The committed `flag_op` is 2'b01 for tagged add and 2'b10 for tagged subtract. 2'b00 means no operation has been committed.
- R9: While `rst_n` is 0, `trap`, `res_valid`, `result` and every flag-bundle output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| result | output | 32 | Arithmetic result of the last strobed operation |
| res_valid | output | 1 | Last strobed operation completed without trap |
| trap | output | 1 | Last strobed operation raised a tag-overflow trap |
| flag_op | output | 2 | Committed operation code |
| flag_src_a | output | 32 | Committed first operand |
| flag_src_b | output | 32 | Committed second operand |
| flag_res | output | 32 | Committed result |

## Verification
The hardest situation to reach is a trap arriving directly after a clean operation. In that case the flag bundle must freeze on the just-committed values while `result` moves on to the faulting sum. The stimulus therefore runs clean and trapping operations back to back with no idle cycle between them.

Overflow without a tag fault needs operands that are multiples of four close to the signed limits. The bench uses such values for both signs and both operations. It also includes cases with differing signs that sit just inside the limit, to confirm that no false trap is raised there.

// File: rtl/tagarith_pkg.sv
package tagarith_pkg;
  typedef enum logic [1:0] {
    FOP_NONE = 2'b00,
    FOP_TADD = 2'b01,
    FOP_TSUB = 2'b10
  } fop_e;
endpackage

// File: rtl/tat_tag_check.sv
module tat_tag_check #(
  parameter int TAG_W = 2
) (
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  output logic             tag_fault
);
  function automatic logic tag_dirty(input logic [TAG_W-1:0] t);
    return |t;
  endfunction

  assign tag_fault = tag_dirty(tag_a) | tag_dirty(tag_b);
endmodule

// File: rtl/tat_addsub.sv
module tat_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_fault
);
  localparam int MSB = DATA_W - 1;

  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  always_comb begin
    if (do_sub) begin
      sum       = opnd_a - opnd_b;
      ovf_fault = sub_ovf(opnd_a[MSB], opnd_b[MSB], sum[MSB]);
    end else begin
      sum       = opnd_a + opnd_b;
      ovf_fault = add_ovf(opnd_a[MSB], opnd_b[MSB], sum[MSB]);
    end
  end
endmodule

// File: rtl/tat_flag_reg.sv
module tat_flag_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [1:0]        op_code,
  input  logic [DATA_W-1:0] cap_a,
  input  logic [DATA_W-1:0] cap_b,
  input  logic [DATA_W-1:0] cap_r,
  output logic [1:0]        fl_op,
  output logic [DATA_W-1:0] fl_a,
  output logic [DATA_W-1:0] fl_b,
  output logic [DATA_W-1:0] fl_r
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_op <= tagarith_pkg::FOP_NONE;
      fl_a  <= '0;
      fl_b  <= '0;
      fl_r  <= '0;
    end else if (commit) begin
      fl_op <= op_code;
      fl_a  <= cap_a;
      fl_b  <= cap_b;
      fl_r  <= cap_r;
    end
  end
endmodule

// File: rtl/tagged_arith_trap.sv
module tagged_arith_trap #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              res_valid,
  output logic              trap,
  output logic [1:0]        flag_op,
  output logic [DATA_W-1:0] flag_src_a,
  output logic [DATA_W-1:0] flag_src_b,
  output logic [DATA_W-1:0] flag_res
);
  import tagarith_pkg::*;

  logic              tag_fault;
  logic              ovf_fault;
  logic              any_fault;
  logic              commit;
  logic [DATA_W-1:0] sum;
  logic [1:0]        op_code;

  tat_tag_check #(.TAG_W(TAG_W)) u_tag (
    .tag_a     (src_a[TAG_W-1:0]),
    .tag_b     (src_b[TAG_W-1:0]),
    .tag_fault (tag_fault)
  );

  tat_addsub #(.DATA_W(DATA_W)) u_alu (
    .opnd_a    (src_a),
    .opnd_b    (src_b),
    .do_sub    (op_sub),
    .sum       (sum),
    .ovf_fault (ovf_fault)
  );

  assign any_fault = tag_fault | ovf_fault;
  assign commit    = in_valid & ~any_fault;
  assign op_code   = op_sub ? FOP_TSUB : FOP_TADD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap      <= 1'b0;
      res_valid <= 1'b0;
      result    <= '0;
    end else begin
      trap      <= in_valid & any_fault;
      res_valid <= commit;
      if (in_valid) result <= sum;
    end
  end

  tat_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .op_code (op_code),
    .cap_a   (src_a),
    .cap_b   (src_b),
    .cap_r   (sum),
    .fl_op   (flag_op),
    .fl_a    (flag_src_a),
    .fl_b    (flag_src_b),
    .fl_r    (flag_res)
  );
endmodule

// File: rtl/tagged_arith_trap_chk.sv
module tagged_arith_trap_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              op_sub,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              tag_fault,
  input logic              ovf_fault,
  input logic              trap,
  input logic              res_valid,
  input logic [DATA_W-1:0] result,
  input logic [1:0]        flag_op,
  input logic [DATA_W-1:0] flag_src_a,
  input logic [DATA_W-1:0] flag_src_b,
  input logic [DATA_W-1:0] flag_res
);
  assert_tag_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && tag_fault |=> trap);

  assert_add_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op_sub && ovf_fault |=> trap);

  assert_sub_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sub && ovf_fault |=> trap);

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && res_valid));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !trap && !res_valid);

  assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> flag_res == result && flag_src_a == $past(src_a)
                  && flag_src_b == $past(src_b));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $stable(flag_op) && $stable(flag_src_a)
             && $stable(flag_src_b) && $stable(flag_res));

  assert_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> flag_op == ($past(op_sub) ? 2'b10 : 2'b01));
endmodule

bind tagged_arith_trap tagged_arith_trap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_sub     (op_sub),
  .src_a      (src_a),
  .src_b      (src_b),
  .tag_fault  (tag_fault),
  .ovf_fault  (ovf_fault),
  .trap       (trap),
  .res_valid  (res_valid),
  .result     (result),
  .flag_op    (flag_op),
  .flag_src_a (flag_src_a),
  .flag_src_b (flag_src_b),
  .flag_res   (flag_res)
);

// File: tb/tagged_arith_trap_tb.sv
module tagged_arith_trap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] result, flag_src_a, flag_src_b, flag_res;
  logic        res_valid, trap;
  logic [1:0]  flag_op;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic        trap;
    logic        rv;
    logic [31:0] res;
    logic [1:0]  fop;
    logic [31:0] fa, fb, fr;
    string       treq;
  } exp_t;
  exp_t q[$];

  logic [1:0]  m_op = 2'b00;
  logic [31:0] m_a = '0, m_b = '0, m_r = '0, m_res = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tagged_arith_trap u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .src_a(src_a), .src_b(src_b), .result(result), .res_valid(res_valid),
    .trap(trap), .flag_op(flag_op), .flag_src_a(flag_src_a),
    .flag_src_b(flag_src_b), .flag_res(flag_res)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: drives one cycle and pushes the independent expectation.
  task automatic drive(input logic v, input logic sub, input logic [31:0] a, input logic [31:0] b);
    logic signed [33:0] full;
    logic tagbad, ovf;
    exp_t e;
    @(negedge clk);
    in_valid = v; op_sub = sub; src_a = a; src_b = b;
    full = sub ? ($signed({{2{a[31]}}, a}) - $signed({{2{b[31]}}, b}))
               : ($signed({{2{a[31]}}, a}) + $signed({{2{b[31]}}, b}));
    tagbad = (a[1:0] != 2'b00) || (b[1:0] != 2'b00);
    ovf = (full[33:31] != 3'b000) && (full[33:31] != 3'b111);
    e.due = cyc + 1;
    e.trap = v && (tagbad || ovf);
    e.rv = v && !(tagbad || ovf);
    if (v) m_res = full[31:0];
    e.res = m_res;
    if (e.rv) begin
      m_op = sub ? 2'b10 : 2'b01;
      m_a = a; m_b = b; m_r = full[31:0];
    end
    e.fop = m_op; e.fa = m_a; e.fb = m_b; e.fr = m_r;
    e.treq = !v ? "R4" : tagbad ? "R1" : sub ? "R3" : "R2";
    q.push_back(e);
  endtask

  // Monitor: pops expectations once their result cycle is reached.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        check(e.treq, {31'd0, trap}, {31'd0, e.trap});
        check("R4", {31'd0, res_valid}, {31'd0, e.rv});
        check("R5", result, e.res);
        if (e.rv) begin
          check("R6", flag_src_a, e.fa);
          check("R6", flag_src_b, e.fb);
          check("R6", flag_res, e.fr);
          check("R8", {30'd0, flag_op}, {30'd0, e.fop});
        end else begin
          check("R7", flag_src_a, e.fa);
          check("R7", flag_src_b, e.fb);
          check("R7", flag_res, e.fr);
          check("R7", {30'd0, flag_op}, {30'd0, e.fop});
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {31'd0, trap}, 32'd0);
    check("R9", {31'd0, res_valid}, 32'd0);
    check("R9", result, 32'd0);
    check("R9", {30'd0, flag_op}, 32'd0);
    check("R9", flag_src_a, 32'd0);
    check("R9", flag_res, 32'd0);
    rst_n = 1'b1;
    drive(0, 0, 32'h0, 32'h0);
    drive(1, 0, 32'h0000_0010, 32'h0000_0024);   // clean add
    drive(1, 1, 32'h0000_0100, 32'h0000_0200);   // clean sub, negative result
    drive(1, 0, 32'h0000_0011, 32'h0000_0004);   // R1 tag bit0 in a
    drive(1, 1, 32'h0000_0008, 32'h0000_0002);   // R1 tag bit1 in b
    drive(1, 0, 32'h7FFF_FFFC, 32'h0000_0004);   // R2 positive overflow
    drive(1, 0, 32'h8000_0000, 32'hFFFF_FFFC);   // R2 negative overflow
    drive(1, 0, 32'h7FFF_FFF8, 32'h0000_0004);   // add just inside limit
    drive(1, 0, 32'h7FFF_FFFC, 32'h8000_0000);   // differing signs, no overflow
    drive(1, 1, 32'h8000_0000, 32'h0000_0004);   // R3 negative overflow
    drive(1, 1, 32'h7FFF_FFFC, 32'hFFFF_FFFC);   // R3 positive overflow
    drive(1, 1, 32'h8000_0004, 32'h0000_0004);   // sub just inside limit
    drive(1, 1, 32'hFFFF_FFFC, 32'h7FFF_FFFC);   // diff signs, no overflow
    drive(1, 0, 32'h7FFF_FFFF, 32'h0000_0004);   // tag and overflow together
    drive(0, 1, 32'h0000_0003, 32'h0000_0003);   // idle with dirty inputs
    drive(1, 1, 32'h0000_1000, 32'h0000_0400);   // clean then trap back to back
    drive(1, 1, 32'h0000_1000, 32'h0000_0401);
    drive(1, 0, 32'h1234_5670, 32'h0000_0008);
    drive(0, 0, 32'h0, 32'h0);
    for (int i = 0; i < 40; i++)
      drive(1, i[0], {i[7:0], 24'h00_0000} ^ 32'h7F00_0000, {i[5:0] + 6'd3, 26'd0} | {30'd0, i[3:2] & 2'b01});
    drive(0, 0, 32'h0, 32'h0);
    drive(0, 0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule